// File: doc/BRIEF.md
# DMA Request and Interrupt Router

This block is the control front end of a multi-channel DMA controller. Peripherals raise hardware request lines. Software raises requests by writing a register. The router keeps a per-channel enable mask, collects the pending requests of enabled channels and hands exactly one channel at a time to a transfer engine. The handover uses a start pulse and a done/error reply. The data movement, descriptor fetch and bus mastering all sit in that engine, outside this block.

A parameter marks each of the 32 channels as either a dedicated software channel or a channel owned by a peripheral. This marking decides where a completion is reported. A finished transfer on a peripheral channel pulses that channel's bit of `periph_done`, even when software started the transfer. A finished transfer on a dedicated software channel pulses `sw_irq` instead. When the engine reports a bus or protection fault, the router does three things: it disables the failing channel, sets a sticky error flag and holds `err_irq` high until software clears the flag.

Nothing is granted until the master enable is set. The router also stores the control-table base pointer for the engine. The pointer is always aligned to 1 KiB.

Top module: `dma_req_router`

## Requirements
- R1: No transfer is started while the master enable (bit 0 of register 0) is 0. Requests stay pending and are granted once the enable is set.
- R2: Writing register 1 sets every channel-enable bit where the write data is 1. Writing register 2 clears them. Both registers read back the enable mask.
- R3: Writing 1 to a bit of register 3 makes that channel's software request pending only if the channel is enabled at that moment. The pending bit clears itself when the channel is granted. Register 3 reads back the pending bits.
- R4: Hardware request lines are level-sensitive. They count only for peripheral channels that are enabled, are sampled only while no transfer is outstanding, and re-request while they stay high. A hardware line on a dedicated software channel has no effect.
- R5: Among the requesting channels, the lowest channel number is granted first.
- R6: A grant shows as a one-cycle `xfer_start` with the channel on `xfer_chan`, one cycle after the grant decision. No further `xfer_start` occurs until `xfer_done` or `xfer_err` has been seen for the outstanding transfer.
- R7: When a transfer on a peripheral channel completes, `periph_done` pulses that channel's bit for exactly one cycle, one cycle after `xfer_done`. `sw_irq` stays low.
- R8: When a transfer on a dedicated software channel completes, `sw_irq` pulses for one cycle, one cycle after `xfer_done`. `periph_done` stays zero.
- R9: `xfer_err` clears the enable bit of the outstanding channel, sets the sticky error flag and raises `err_irq` in the next cycle. An error takes precedence over a simultaneous done.
- R10: The sticky flag reads as bit 0 of register 4. Writing 1 there clears it and drops `err_irq`. A new error in the same cycle wins over the clear.
- R11: Register 5 holds the control-table base. Bits 9:0 are forced to 0 on write and read back as 0, and the stored value drives `tbl_base`.
- R12: After reset, all registers are 0, no request is pending and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 config, 1 enable set, 2 enable clear, 3 software request, 4 error, 5 table base) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| hw_req | input | 32 | Level hardware requests, one per channel |
| xfer_start | output | 1 | One-cycle start pulse to the transfer engine |
| xfer_chan | output | 5 | Channel of the outstanding transfer |
| xfer_done | input | 1 | Engine reports successful completion |
| xfer_err | input | 1 | Engine reports a bus or protection fault |
| tbl_base | output | 32 | Aligned control-table base pointer |
| periph_done | output | 32 | One-cycle completion pulse per peripheral channel |
| sw_irq | output | 1 | Completion pulse for dedicated software channels |
| err_irq | output | 1 | Error interrupt level, follows the sticky flag |

## Verification
The bench aims at these corner cases:
- A software request made on a peripheral channel. A router that keyed routing on the request source would raise `sw_irq` instead of the peripheral's done bit.
- Two requests written in the same cycle. Wrong priority shows up as the higher channel starting first.
- A hardware line held high through several transfers, and a hardware line placed on a software-only channel. A design that ignored the channel type would start transfers that should never happen.
- Faults. A faulted channel that stayed enabled would accept a later request. An error flag that did not stick, or ignored the write-one clear, would show a wrong `err_irq` level.
- Requests written while the master enable is off, and requests to a disabled channel. A design that leaked either would start a transfer early.

// File: rtl/dma_rr_pkg.sv
`timescale 1ns/1ps
package dma_rr_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned ALIGN_BITS = 10;

  typedef enum logic [SEL_W-1:0] {
    SEL_CFG    = 3'd0,
    SEL_EN_SET = 3'd1,
    SEL_EN_CLR = 3'd2,
    SEL_SWREQ  = 3'd3,
    SEL_ERR    = 3'd4,
    SEL_BASE   = 3'd5
  } reg_sel_e;

  // Force the table pointer onto a 1 KiB boundary.
  function automatic logic [DATA_W-1:0] align_base(input logic [DATA_W-1:0] a);
    return a & ~((DATA_W'(1) << ALIGN_BITS) - DATA_W'(1));
  endfunction
endpackage

// File: rtl/dma_rr_regs.sv
`timescale 1ns/1ps
module dma_rr_regs
  import dma_rr_pkg::*;
#(
  parameter int unsigned NCH = 32,
  parameter int unsigned CW  = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SEL_W-1:0]      addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  input  logic                  grant_fire,
  input  logic [CW-1:0]         grant_chan,
  input  logic                  fault_fire,
  input  logic [CW-1:0]         fault_chan,
  output logic                  master_en,
  output logic [NCH-1:0]        chan_en,
  output logic [NCH-1:0]        sw_pend,
  output logic                  err_flag,
  output logic [DATA_W-1:0]     tbl_base
);
  reg_sel_e sel;
  logic [NCH-1:0] en_n, sw_n;
  logic           err_n;

  assign sel = reg_sel_e'(addr);

  always_comb begin
    en_n = chan_en;
    if (we && sel == SEL_EN_SET) en_n = en_n | wdata[NCH-1:0];
    if (we && sel == SEL_EN_CLR) en_n = en_n & ~wdata[NCH-1:0];
    if (fault_fire)              en_n[fault_chan] = 1'b0;

    sw_n = sw_pend;
    if (grant_fire)              sw_n[grant_chan] = 1'b0;
    if (we && sel == SEL_SWREQ)  sw_n = sw_n | (wdata[NCH-1:0] & chan_en);

    err_n = err_flag;
    if (we && sel == SEL_ERR && wdata[0]) err_n = 1'b0;
    if (fault_fire)                       err_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_en <= 1'b0;
      chan_en   <= '0;
      sw_pend   <= '0;
      err_flag  <= 1'b0;
      tbl_base  <= '0;
    end else begin
      if (we && sel == SEL_CFG)  master_en <= wdata[0];
      if (we && sel == SEL_BASE) tbl_base  <= align_base(wdata);
      chan_en  <= en_n;
      sw_pend  <= sw_n;
      err_flag <= err_n;
    end
  end

  always_comb begin
    case (sel)
      SEL_CFG:               rdata = DATA_W'(master_en);
      SEL_EN_SET, SEL_EN_CLR: rdata = DATA_W'(chan_en);
      SEL_SWREQ:             rdata = DATA_W'(sw_pend);
      SEL_ERR:               rdata = DATA_W'(err_flag);
      SEL_BASE:              rdata = tbl_base;
      default:               rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_rr_arb.sv
`timescale 1ns/1ps
module dma_rr_arb #(
  parameter int unsigned NCH = 32,
  parameter int unsigned CW  = $clog2(NCH)
) (
  input  logic [NCH-1:0] cand,
  output logic           any,
  output logic [CW-1:0]  idx
);
  logic [NCH:0]   seen;
  logic [NCH-1:0] win;

  assign seen[0] = 1'b0;
  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chain
      assign win[g]    = cand[g] & ~seen[g];
      assign seen[g+1] = seen[g] | cand[g];
    end
  endgenerate

  assign any = seen[NCH];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++)
      if (win[i]) idx = CW'(i);
  end
endmodule

// File: rtl/dma_rr_seq.sv
`timescale 1ns/1ps
module dma_rr_seq #(
  parameter int unsigned     NCH        = 32,
  parameter int unsigned     CW         = $clog2(NCH),
  parameter logic [NCH-1:0]  SW_CH_MASK = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [CW-1:0]  req_chan,
  input  logic           xfer_done,
  input  logic           xfer_err,
  output logic           grant_fire,
  output logic           fault_fire,
  output logic           cmpl_fire,
  output logic           busy,
  output logic [CW-1:0]  act_chan,
  output logic           xfer_start,
  output logic [NCH-1:0] periph_done,
  output logic           sw_irq
);
  assign grant_fire = !busy && req_valid;
  assign fault_fire = busy && xfer_err;
  assign cmpl_fire  = busy && xfer_done && !xfer_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      act_chan    <= '0;
      xfer_start  <= 1'b0;
      periph_done <= '0;
      sw_irq      <= 1'b0;
    end else begin
      xfer_start  <= grant_fire;
      periph_done <= '0;
      sw_irq      <= 1'b0;
      if (grant_fire) begin
        busy     <= 1'b1;
        act_chan <= req_chan;
      end else if (fault_fire) begin
        busy <= 1'b0;
      end else if (cmpl_fire) begin
        busy <= 1'b0;
        if (SW_CH_MASK[act_chan]) sw_irq <= 1'b1;
        else                      periph_done[act_chan] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_req_router.sv
`timescale 1ns/1ps
module dma_req_router
  import dma_rr_pkg::*;
#(
  parameter int unsigned    NCH        = 32,
  parameter int unsigned    CW         = $clog2(NCH),
  parameter logic [NCH-1:0] SW_CH_MASK = 32'hC000_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    hw_req,
  output logic              xfer_start,
  output logic [CW-1:0]     xfer_chan,
  input  logic              xfer_done,
  input  logic              xfer_err,
  output logic [DATA_W-1:0] tbl_base,
  output logic [NCH-1:0]    periph_done,
  output logic              sw_irq,
  output logic              err_irq
);
  logic           master_en, err_flag, busy;
  logic [NCH-1:0] chan_en, sw_pend, cand;
  logic           req_valid, grant_fire, fault_fire, cmpl_fire;
  logic [CW-1:0]  grant_chan, act_chan;

  // Hardware lines count only on enabled peripheral channels.
  assign cand = master_en ? (chan_en & (sw_pend | (hw_req & ~SW_CH_MASK))) : '0;

  dma_rr_regs #(.NCH(NCH), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .grant_fire(grant_fire), .grant_chan(grant_chan),
    .fault_fire(fault_fire), .fault_chan(act_chan), .master_en(master_en),
    .chan_en(chan_en), .sw_pend(sw_pend), .err_flag(err_flag), .tbl_base(tbl_base)
  );

  dma_rr_arb #(.NCH(NCH), .CW(CW)) u_arb (
    .cand(cand), .any(req_valid), .idx(grant_chan)
  );

  dma_rr_seq #(.NCH(NCH), .CW(CW), .SW_CH_MASK(SW_CH_MASK)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(grant_chan),
    .xfer_done(xfer_done), .xfer_err(xfer_err), .grant_fire(grant_fire),
    .fault_fire(fault_fire), .cmpl_fire(cmpl_fire), .busy(busy),
    .act_chan(act_chan), .xfer_start(xfer_start), .periph_done(periph_done),
    .sw_irq(sw_irq)
  );

  assign xfer_chan = act_chan;
  assign err_irq   = err_flag;
endmodule

// File: rtl/dma_rr_chk.sv
`timescale 1ns/1ps
module dma_rr_chk #(
  parameter int unsigned    NCH        = 32,
  parameter int unsigned    CW         = $clog2(NCH),
  parameter logic [NCH-1:0] SW_CH_MASK = '0
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr_wr,
  input logic           xfer_start,
  input logic           xfer_done,
  input logic           xfer_err,
  input logic [NCH-1:0] periph_done,
  input logic           sw_irq,
  input logic           err_irq,
  input logic [9:0]     base_lo,
  input logic [CW-1:0]  act_chan,
  input logic           master_en,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] cand,
  input logic           busy,
  input logic           grant_fire,
  input logic [CW-1:0]  grant_chan,
  input logic           fault_fire,
  input logic           cmpl_fire
);
  AST_GRANT_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> master_en); // R1
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> ((cand & ((NCH'(1) << grant_chan) - NCH'(1))) == '0)); // R5
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start); // R6
  AST_WAIT_FOR_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done && !xfer_err) |=> !xfer_start); // R6
  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(periph_done)); // R7
  AST_SWIRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_irq |-> (periph_done == '0)); // R8
  AST_SW_CHANNEL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_fire && SW_CH_MASK[act_chan]) |=> sw_irq); // R8
  AST_FAULT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    fault_fire |=> !chan_en[$past(act_chan)]); // R9
  AST_FAULT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    fault_fire |=> err_irq); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq && !clr_wr) |=> err_irq); // R10
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    base_lo == 10'd0); // R11
endmodule

bind dma_req_router dma_rr_chk #(.NCH(NCH), .CW(CW), .SW_CH_MASK(SW_CH_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .clr_wr(reg_we && reg_addr == 3'd4 && reg_wdata[0]),
  .xfer_start(xfer_start), .xfer_done(xfer_done), .xfer_err(xfer_err),
  .periph_done(periph_done), .sw_irq(sw_irq), .err_irq(err_irq),
  .base_lo(tbl_base[9:0]), .act_chan(act_chan), .master_en(master_en),
  .chan_en(chan_en), .cand(cand), .busy(busy), .grant_fire(grant_fire),
  .grant_chan(grant_chan), .fault_fire(fault_fire), .cmpl_fire(cmpl_fire)
);

// File: tb/test_dma_req_router.sv
`timescale 1ns/1ps
module test_dma_req_router;
  localparam int NCH = 32;
  localparam logic [31:0] SWM = 32'hC000_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] hw_req = '0;
  logic        xfer_start;
  logic [4:0]  xfer_chan;
  logic        xfer_done = 1'b0;
  logic        xfer_err = 1'b0;
  logic [31:0] tbl_base;
  logic [31:0] periph_done;
  logic        sw_irq, err_irq;

  always #4 clk = ~clk; // 125 MHz

  dma_req_router #(.NCH(NCH), .SW_CH_MASK(SWM)) i_dma_req_router (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
    .xfer_start(xfer_start), .xfer_chan(xfer_chan), .xfer_done(xfer_done),
    .xfer_err(xfer_err), .tbl_base(tbl_base), .periph_done(periph_done),
    .sw_irq(sw_irq), .err_irq(err_irq)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit          m_master, m_busy, m_start, m_swirq, m_err;
  bit [31:0]   m_en, m_sw, m_pdone, m_base, en_old;
  int          m_act, pick;
  bit          m_fault;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_master = 0; m_busy = 0; m_start = 0; m_swirq = 0; m_err = 0;
      m_en = 0; m_sw = 0; m_pdone = 0; m_base = 0; m_act = 0;
    end else begin
      pick = -1;
      if (m_master)
        for (int i = 0; i < NCH; i++)
          if (pick < 0 && m_en[i] && (m_sw[i] || (!SWM[i] && hw_req[i]))) pick = i;
      en_old = m_en;
      m_start = 0; m_swirq = 0; m_pdone = 0; m_fault = 0;
      if (!m_busy && pick >= 0) begin
        m_busy = 1; m_act = pick; m_sw[pick] = 0; m_start = 1;
      end else if (m_busy && xfer_err) begin
        m_busy = 0; m_fault = 1;
      end else if (m_busy && xfer_done) begin
        m_busy = 0;
        if (SWM[m_act]) m_swirq = 1; else m_pdone[m_act] = 1;
      end
      if (reg_we) case (reg_addr)
        3'd0: m_master = reg_wdata[0];
        3'd1: m_en = m_en | reg_wdata;
        3'd2: m_en = m_en & ~reg_wdata;
        3'd3: m_sw = m_sw | (reg_wdata & en_old);
        3'd4: if (reg_wdata[0]) m_err = 0;
        3'd5: m_base = {reg_wdata[31:10], 10'd0};
        default: ;
      endcase
      if (m_fault) begin m_en[m_act] = 0; m_err = 1; end
    end
  end

  function automatic logic [31:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_master};
      3'd1, 3'd2: return m_en;
      3'd3: return m_sw;
      3'd4: return {31'd0, m_err};
      3'd5: return m_base;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_req(input logic [2:0] a);
    case (a)
      3'd0: return "R1 cfg readback";
      3'd1, 3'd2: return "R2 enable readback";
      3'd3: return "R3 swreq readback";
      3'd4: return "R10 error readback";
      3'd5: return "R11 base readback";
      default: return "R12 unused readback";
    endcase
  endfunction

  // Engine model and per-cycle comparison
  int  eng_lat = 2;
  bit  eng_fail = 0;
  bit  eng_arm = 0, eng_bad = 0;
  int  eng_cnt = 0;

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk("R6 xfer_start", {31'd0, xfer_start}, {31'd0, m_start});
      if (m_start) chk("R5 xfer_chan", {27'd0, xfer_chan}, 32'(m_act));
      chk("R7 periph_done", periph_done, m_pdone);
      chk("R8 sw_irq", {31'd0, sw_irq}, {31'd0, m_swirq});
      chk("R9 err_irq", {31'd0, err_irq}, {31'd0, m_err});
      chk("R11 tbl_base", tbl_base, m_base);
      chk(rd_req(reg_addr), reg_rdata, m_rd(reg_addr));
    end
    xfer_done = 0; xfer_err = 0;
    if (xfer_start) begin eng_arm = 1; eng_cnt = eng_lat; eng_bad = eng_fail; end
    if (eng_arm) begin
      if (eng_cnt == 0) begin
        if (eng_bad) xfer_err = 1; else xfer_done = 1;
        eng_arm = 0;
      end else eng_cnt--;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk); #2;
    // R12: reset state at the ports
    chk("R12 reset outputs", {xfer_start, sw_irq, err_irq}, 32'd0);
    chk("R12 reset periph_done", periph_done, 32'd0);
    chk("R12 reset base", tbl_base, 32'd0);
    // R11: unaligned base
    wr(3'd5, 32'h1234_57FF); idle(2);
    // R1: request held while master enable is off
    wr(3'd1, 32'h0000_0026);
    wr(3'd3, 32'h0000_0004); reg_addr = 3'd3; idle(6);
    wr(3'd0, 32'h1); idle(10);
    // R5: two peripheral channels at once, R7 routing of software-started work
    wr(3'd3, 32'h0000_0024); idle(15);
    // R8: dedicated software channel
    wr(3'd3, 32'h0000_0002); idle(10);
    // R3: request to a disabled channel is dropped
    wr(3'd3, 32'h0000_0100); reg_addr = 3'd3; idle(5);
    // R4: level hardware line on channel 10
    wr(3'd1, 32'h0000_0401);
    @(negedge clk); hw_req[10] = 1; idle(14);
    hw_req[10] = 0; idle(6);
    // R4: hardware line on a software-only channel and on a disabled channel
    hw_req[0] = 1; hw_req[12] = 1; idle(8);
    hw_req = '0; idle(2);
    // R9: fault on channel 5
    eng_fail = 1;
    wr(3'd3, 32'h0000_0020); idle(8);
    eng_fail = 0;
    wr(3'd3, 32'h0000_0020); reg_addr = 3'd1; idle(6);
    // R10: clear the sticky flag
    reg_addr = 3'd4; idle(2);
    wr(3'd4, 32'h1); reg_addr = 3'd4; idle(3);
    // R2: disable channel 2, then a request on it is dropped
    wr(3'd2, 32'h0000_0004);
    wr(3'd3, 32'h0000_0004); idle(5);
    // R6: long engine latency with several requests queued
    eng_lat = 20;
    wr(3'd1, 32'h0000_0024);
    wr(3'd3, 32'h0000_0026); idle(80);
    eng_lat = 2;
    // R1: master off blocks a held hardware line
    wr(3'd0, 32'h0); hw_req[5] = 1; idle(8);
    wr(3'd0, 32'h1); idle(6); hw_req = '0; idle(10);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule